// File: doc/BRIEF.md
# Paired Receive/Transmit Peripheral DMA Engine

This block moves data between one serial peripheral and system memory without the processor touching each item. It contains two channels: the receive channel copies words out of the peripheral's receive holding register into memory, and the transmit channel reads words from memory into the peripheral's transmit holding register. The peripheral asks for service with level request lines. The block reaches memory over a single-beat request/grant bus, on which read data returns in the grant cycle.

Each channel keeps a current memory pointer and remaining item count, plus a queued "next" pointer and count. When the current buffer empties, the queued one takes its place in the same clock, so a stream can cross buffer boundaries with no idle cycle. Software programs every pointer, count and control field through a small register port. Each direction reports an end flag once it has nothing left to move. A combined flag reports when both directions are empty.

Top module: `pdma_pair`

## Requirements
- R1: After reset all pointers, counts and control fields read zero, both channels are disabled, `rx_end`, `tx_end` and `all_done` are 1, and `mem_req` is 0.
- R2: Register address bit 3 selects the direction (0 receive, 1 transmit), and bits 2:0 select the field: 0 current pointer, 1 current count, 2 next pointer, 3 next count, 4 control (bit 0 enable, bits 2:1 item size code). `cfg_rdata` returns the field addressed by `cfg_rd_addr` combinationally, with counts zero-extended.
- R3: A transmit item costs one clock. In the cycle where `tx_req` is high and the transmit channel is serviceable, a memory read is issued at the transmit pointer. In its grant cycle `tx_load` pulses and `tx_data` equals `mem_rdata`.
- R4: A receive item costs two clocks. In the cycle where `rx_req` is high and the receive channel is serviceable, `rx_ack` pulses and `rx_data` is captured. In the next cycle, a memory write of the captured word is issued at the receive pointer.
- R5: Each finished item adds the item size to the pointer and subtracts one from the count. Size code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes.
- R6: When the current count becomes zero while the next count is non-zero, the next pointer and count are copied into the current ones in that same clock and the next count is cleared, so service continues without a gap.
- R7: A direction's end flag is 1 exactly when its current and next counts are both zero. `all_done` is 1 when both end flags are 1.
- R8: A channel that is disabled, or whose current count is zero, ignores its request line: no acknowledge, no load, no bus request, and its count is unchanged.
- R9: When both directions are serviceable and requesting while the bus is free, the receive direction is served first.
- R10: An ungranted memory request stays asserted with its address and direction unchanged until it is granted. A waiting transmit read is not pre-empted by a receive request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register write address |
| cfg_wdata | input | AW | Register write data |
| cfg_rd_addr | input | 4 | Register read address |
| cfg_rdata | output | AW | Register read data |
| rx_req | input | 1 | Peripheral has a received word ready |
| rx_data | input | DW | Peripheral receive holding register |
| rx_ack | output | 1 | Receive word taken this cycle |
| tx_req | input | 1 | Peripheral can accept a transmit word |
| tx_data | output | DW | Word for the transmit holding register |
| tx_load | output | 1 | Load `tx_data` this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Item size code |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_rdata | input | DW | Read data, valid with grant |
| rx_end | output | 1 | Receive channel fully drained |
| tx_end | output | 1 | Transmit channel fully drained |
| all_done | output | 1 | Both channels drained |

## Verification
On every cycle, the assertions check the bus hold rule and the timing links between the peripheral strobes and the bus. In particular, a load happens only inside a granted read, and a receive acknowledge is followed by a write. They also check that no strobe fires from an empty channel, that an end flag cannot clear without a register write, and that a plain transmit step lowers the count by exactly one. The pointer step for each size code, the same-cycle reload of a queued buffer, and receive-first ordering need particular programmed sequences. Only the bench's scenarios show those, along with the readback of registers after ignored requests.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
   localparam int unsigned DIR_RX = 0;
   localparam int unsigned DIR_TX = 1;

   // field selector within a direction's register window
   localparam logic [2:0] FLD_PTR  = 3'd0;
   localparam logic [2:0] FLD_CNT  = 3'd1;
   localparam logic [2:0] FLD_NPTR = 3'd2;
   localparam logic [2:0] FLD_NCNT = 3'd3;
   localparam logic [2:0] FLD_CTRL = 3'd4;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    size_bytes = 3'd1;
         2'd1:    size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/pdma_chan.sv
module pdma_chan
   import pdma_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [AW-1:0] wr_data,
   input  logic          adv,
   output logic [AW-1:0] cur_ptr,
   output logic [CW-1:0] cur_cnt,
   output logic [AW-1:0] nxt_ptr,
   output logic [CW-1:0] nxt_cnt,
   output logic          en,
   output logic [1:0]    size,
   output logic          ready,
   output logic          done
);
   logic [AW-1:0] ptr_q, ptr_d, nptr_q, nptr_d;
   logic [CW-1:0] cnt_q, cnt_d, ncnt_q, ncnt_d;
   logic          en_q, en_d;
   logic [1:0]    size_q, size_d;

   always_comb begin
      ptr_d  = ptr_q;
      cnt_d  = cnt_q;
      nptr_d = nptr_q;
      ncnt_d = ncnt_q;
      en_d   = en_q;
      size_d = size_q;
      if (adv) begin
         ptr_d = ptr_q + AW'(size_bytes(size_q));
         cnt_d = cnt_q - 1'b1;
      end
      if (wr_en) begin
         case (wr_sel)
            FLD_PTR:  ptr_d  = wr_data;
            FLD_CNT:  cnt_d  = wr_data[CW-1:0];
            FLD_NPTR: nptr_d = wr_data;
            FLD_NCNT: ncnt_d = wr_data[CW-1:0];
            FLD_CTRL: begin
               en_d   = wr_data[0];
               size_d = wr_data[2:1];
            end
            default: ;
         endcase
      end
      // chain the queued buffer in the same clock the current one empties
      if (cnt_d == '0 && ncnt_d != '0) begin
         ptr_d  = nptr_d;
         cnt_d  = ncnt_d;
         ncnt_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         cnt_q  <= '0;
         nptr_q <= '0;
         ncnt_q <= '0;
         en_q   <= 1'b0;
         size_q <= 2'd0;
      end else begin
         ptr_q  <= ptr_d;
         cnt_q  <= cnt_d;
         nptr_q <= nptr_d;
         ncnt_q <= ncnt_d;
         en_q   <= en_d;
         size_q <= size_d;
      end
   end

   assign cur_ptr = ptr_q;
   assign cur_cnt = cnt_q;
   assign nxt_ptr = nptr_q;
   assign nxt_cnt = ncnt_q;
   assign en      = en_q;
   assign size    = size_q;
   assign ready   = en_q && (cnt_q != '0);
   assign done    = (cnt_q == '0) && (ncnt_q == '0);
endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_rdy,
   input  logic          tx_rdy,
   input  logic          rx_req,
   input  logic          tx_req,
   input  logic [AW-1:0] rx_ptr,
   input  logic [AW-1:0] tx_ptr,
   input  logic [1:0]    rx_size,
   input  logic [1:0]    tx_size,
   input  logic [DW-1:0] rx_data,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   output logic          rx_ack,
   output logic          tx_load,
   output logic [DW-1:0] tx_data,
   output logic          rx_adv,
   output logic          tx_adv
);
   logic          rx_wr_q, rx_wr_d;
   logic          tx_wait_q, tx_wait_d;
   logic [DW-1:0] rx_buf_q, rx_buf_d;
   logic          tx_go;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = tx_ptr;
      mem_size  = tx_size;
      mem_wdata = rx_buf_q;
      rx_ack    = 1'b0;
      tx_load   = 1'b0;
      rx_adv    = 1'b0;
      tx_adv    = 1'b0;
      rx_wr_d   = rx_wr_q;
      tx_wait_d = tx_wait_q;
      rx_buf_d  = rx_buf_q;
      tx_go     = 1'b0;
      if (rx_wr_q) begin
         // second clock of a receive item: write the captured word
         mem_req  = 1'b1;
         mem_we   = 1'b1;
         mem_addr = rx_ptr;
         mem_size = rx_size;
         if (mem_gnt) begin
            rx_adv  = 1'b1;
            rx_wr_d = 1'b0;
         end
      end else if (tx_wait_q) begin
         tx_go = 1'b1;
      end else if (rx_req && rx_rdy) begin
         rx_ack   = 1'b1;
         rx_buf_d = rx_data;
         rx_wr_d  = 1'b1;
      end else if (tx_req && tx_rdy) begin
         tx_go = 1'b1;
      end
      if (tx_go) begin
         mem_req = 1'b1;
         if (mem_gnt) begin
            tx_load   = 1'b1;
            tx_adv    = 1'b1;
            tx_wait_d = 1'b0;
         end else begin
            tx_wait_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_wr_q   <= 1'b0;
         tx_wait_q <= 1'b0;
         rx_buf_q  <= '0;
      end else begin
         rx_wr_q   <= rx_wr_d;
         tx_wait_q <= tx_wait_d;
         rx_buf_q  <= rx_buf_d;
      end
   end

   assign tx_data = mem_rdata;
endmodule

// File: rtl/pdma_pair.sv
module pdma_pair
   import pdma_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 16,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr_en,
   input  logic [3:0]    cfg_wr_addr,
   input  logic [AW-1:0] cfg_wdata,
   input  logic [3:0]    cfg_rd_addr,
   output logic [AW-1:0] cfg_rdata,
   input  logic          rx_req,
   input  logic [DW-1:0] rx_data,
   output logic          rx_ack,
   input  logic          tx_req,
   output logic [DW-1:0] tx_data,
   output logic          tx_load,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata,
   output logic          rx_end,
   output logic          tx_end,
   output logic          all_done
);
   localparam int unsigned NDIR = 2;

   if (AW < 16 || AW > 32) begin : g_bad_aw
      $error("pdma_pair: AW must be within 16..32");
   end
   if (CW < 2 || CW > AW) begin : g_bad_cw
      $error("pdma_pair: CW must be within 2..AW");
   end
   if (DW < 8) begin : g_bad_dw
      $error("pdma_pair: DW must be at least 8");
   end

   logic [AW-1:0] ptr_w  [NDIR];
   logic [AW-1:0] nptr_w [NDIR];
   logic [CW-1:0] cnt_w  [NDIR];
   logic [CW-1:0] ncnt_w [NDIR];
   logic [1:0]    size_w [NDIR];
   logic          en_w   [NDIR];
   logic          ready_w[NDIR];
   logic          done_w [NDIR];
   logic          adv_w  [NDIR];

   for (genvar d = 0; d < NDIR; d++) begin : g_chan
      pdma_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_wr_en && (cfg_wr_addr[3] == 1'(d))),
         .wr_sel  (cfg_wr_addr[2:0]),
         .wr_data (cfg_wdata),
         .adv     (adv_w[d]),
         .cur_ptr (ptr_w[d]),
         .cur_cnt (cnt_w[d]),
         .nxt_ptr (nptr_w[d]),
         .nxt_cnt (ncnt_w[d]),
         .en      (en_w[d]),
         .size    (size_w[d]),
         .ready   (ready_w[d]),
         .done    (done_w[d])
      );
   end

   pdma_xfer #(.AW(AW), .DW(DW)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_rdy    (ready_w[DIR_RX]),
      .tx_rdy    (ready_w[DIR_TX]),
      .rx_req    (rx_req),
      .tx_req    (tx_req),
      .rx_ptr    (ptr_w[DIR_RX]),
      .tx_ptr    (ptr_w[DIR_TX]),
      .rx_size   (size_w[DIR_RX]),
      .tx_size   (size_w[DIR_TX]),
      .rx_data   (rx_data),
      .mem_gnt   (mem_gnt),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_size  (mem_size),
      .mem_wdata (mem_wdata),
      .rx_ack    (rx_ack),
      .tx_load   (tx_load),
      .tx_data   (tx_data),
      .rx_adv    (adv_w[DIR_RX]),
      .tx_adv    (adv_w[DIR_TX])
   );

   logic rd_dir;
   assign rd_dir = cfg_rd_addr[3];

   always_comb begin
      cfg_rdata = '0;
      case (cfg_rd_addr[2:0])
         FLD_PTR:  cfg_rdata = ptr_w[rd_dir];
         FLD_CNT:  cfg_rdata = AW'(cnt_w[rd_dir]);
         FLD_NPTR: cfg_rdata = nptr_w[rd_dir];
         FLD_NCNT: cfg_rdata = AW'(ncnt_w[rd_dir]);
         FLD_CTRL: cfg_rdata[2:0] = {size_w[rd_dir], en_w[rd_dir]};
         default:  cfg_rdata = '0;
      endcase
   end

   assign rx_end   = done_w[DIR_RX];
   assign tx_end   = done_w[DIR_TX];
   assign all_done = done_w[DIR_RX] && done_w[DIR_TX];
endmodule

// File: rtl/pdma_pair_chk.sv
module pdma_pair_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_wr_en,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          rx_ack,
   input logic          tx_load,
   input logic          rx_end,
   input logic          tx_end,
   input logic [CW-1:0] rx_cnt,
   input logic [CW-1:0] tx_cnt
);
   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt && !cfg_wr_en |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_tx_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> mem_req && mem_gnt && !mem_we);

   assert_rx_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |=> mem_req && mem_we);

   assert_rx_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |-> rx_cnt != '0);

   assert_tx_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> tx_cnt != '0);

   assert_rx_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |-> !tx_load);

   assert_rx_end_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_end && !cfg_wr_en |=> rx_end);

   assert_tx_end_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end && !cfg_wr_en |=> tx_end);

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load && (tx_cnt > CW'(1)) && !cfg_wr_en |=> tx_cnt == $past(tx_cnt) - 1'b1);
endmodule

bind pdma_pair pdma_pair_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr_en (cfg_wr_en),
   .mem_req   (mem_req),
   .mem_gnt   (mem_gnt),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .rx_ack    (rx_ack),
   .tx_load   (tx_load),
   .rx_end    (rx_end),
   .tx_end    (tx_end),
   .rx_cnt    (cnt_w[0]),
   .tx_cnt    (cnt_w[1])
);

// File: tb/test_pdma_pair.sv
module test_pdma_pair;
   localparam int unsigned AW = 32;
   localparam int unsigned CW = 16;
   localparam int unsigned DW = 32;
   localparam logic [31:0] KEY = 32'h5A5A_0000;

   // register addresses: bit 3 direction, bits 2:0 field
   localparam logic [3:0] RX_PTR = 4'h0, RX_CNT = 4'h1, RX_NCNT = 4'h3, RX_CTRL = 4'h4;
   localparam logic [3:0] TX_PTR = 4'h8, TX_CNT = 4'h9, TX_NPTR = 4'hA, TX_NCNT = 4'hB, TX_CTRL = 4'hC;

   // {size code, start pointer, item count}
   localparam logic [49:0] VEC [4] = '{
      {2'd0, 32'h0000_1000, 16'd3},
      {2'd1, 32'h0000_2002, 16'd4},
      {2'd2, 32'h0000_3000, 16'd2},
      {2'd3, 32'h0000_4004, 16'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [3:0]    cfg_wr_addr = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [3:0]    cfg_rd_addr = '0;
   logic [AW-1:0] cfg_rdata;
   logic          rx_req = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rx_ack;
   logic          tx_req = 1'b0;
   logic [DW-1:0] tx_data;
   logic          tx_load;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_size;
   logic [DW-1:0] mem_wdata;
   logic          mem_gnt = 1'b1;
   logic [DW-1:0] mem_rdata;
   logic          rx_end, tx_end, all_done;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   assign mem_rdata = mem_addr ^ KEY;

   pdma_pair #(.AW(AW), .CW(CW), .DW(DW)) i_pdma_pair (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wdata(cfg_wdata),
      .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(cfg_rdata),
      .rx_req(rx_req), .rx_data(rx_data), .rx_ack(rx_ack),
      .tx_req(tx_req), .tx_data(tx_data), .tx_load(tx_load),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .rx_end(rx_end), .tx_end(tx_end), .all_done(all_done)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wdata = d;
      @(posedge clk);
      #1 cfg_wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      @(negedge clk);
      cfg_rd_addr = a;
      #1 chk(req, "readback", cfg_rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      chk("R1", "rx_end", rx_end, 1);
      chk("R1", "tx_end", tx_end, 1);
      chk("R1", "all_done", all_done, 1);
      chk("R1", "mem_req", mem_req, 0);
      rd_chk("R1", TX_PTR, 0);
      rd_chk("R1", TX_CTRL, 0);
      rd_chk("R1", RX_CNT, 0);

      // R3, R5: table-driven transmit runs, one item per clock
      foreach (VEC[v]) begin
         logic [1:0]  sz = VEC[v][49:48];
         logic [31:0] exp_a = VEC[v][47:16];
         int          n = int'(VEC[v][15:0]);
         int          step = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
         wr(TX_PTR, exp_a);
         wr(TX_CTRL, {29'd0, sz, 1'b1});
         rd_chk("R2", TX_CTRL, {29'd0, sz, 1'b1});
         wr(TX_CNT, n);
         for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_req = 1'b1;
            #1;
            chk("R3", "tx_load", tx_load, 1);
            chk("R5", "read addr", mem_addr, exp_a);
            chk("R3", "tx_data", tx_data, exp_a ^ KEY);
            exp_a = exp_a + step;
         end
         @(negedge clk);
         #1 chk("R8", "load from empty", tx_load, 0);
         tx_req = 1'b0;
         chk("R7", "tx_end", tx_end, 1);
         rd_chk("R5", TX_PTR, exp_a);
      end

      // R4, R5: receive items, two clocks each
      wr(RX_PTR, 32'h0000_8000);
      wr(RX_CTRL, 32'h5);
      wr(RX_CNT, 2);
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         rx_req = 1'b1; rx_data = 32'hC0DE_0000 + i;
         #1;
         chk("R4", "rx_ack", rx_ack, 1);
         chk("R4", "no bus in ack cycle", mem_req, 0);
         @(negedge clk);
         rx_req = 1'b0; rx_data = 32'hDEAD_BEEF;
         #1;
         chk("R4", "write req", {mem_req, mem_we}, 2'b11);
         chk("R5", "write addr", mem_addr, 32'h0000_8000 + 4 * i);
         chk("R4", "write data", mem_wdata, 32'hC0DE_0000 + i);
      end
      @(negedge clk);
      #1 chk("R7", "rx_end", rx_end, 1);

      // R6: chained transmit buffer
      wr(TX_CTRL, 32'h1);
      wr(TX_PTR, 32'h0000_0100);
      wr(TX_CNT, 1);
      wr(TX_NPTR, 32'h0000_0200);
      wr(TX_NCNT, 2);
      @(negedge clk);
      #1 chk("R7", "tx_end with queue", tx_end, 0);
      begin
         logic [31:0] seq [3] = '{32'h100, 32'h200, 32'h201};
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            tx_req = 1'b1;
            cfg_rd_addr = TX_NCNT;
            #1;
            chk("R6", "gapless load", tx_load, 1);
            chk("R6", "chain addr", mem_addr, seq[i]);
            if (i == 1) chk("R6", "next count cleared", cfg_rdata, 0);
         end
      end
      @(negedge clk);
      tx_req = 1'b0;
      #1 chk("R7", "all_done", all_done, 1);

      // R8: disabled receive channel ignores requests
      wr(RX_CTRL, 32'h4);
      wr(RX_CNT, 1);
      @(negedge clk);
      #1;
      chk("R7", "rx_end busy", rx_end, 0);
      chk("R7", "all_done busy", all_done, 0);
      @(negedge clk);
      rx_req = 1'b1;
      #1;
      chk("R8", "rx_ack disabled", rx_ack, 0);
      chk("R8", "mem_req disabled", mem_req, 0);
      @(negedge clk);
      rx_req = 1'b0;
      rd_chk("R8", RX_CNT, 1);
      // R8: enabled transmit with zero count
      @(negedge clk);
      tx_req = 1'b1;
      #1 chk("R8", "tx zero count", {tx_load, mem_req}, 2'b00);
      @(negedge clk);
      tx_req = 1'b0;

      // R9: receive wins a tie
      wr(RX_PTR, 32'h0000_8100);
      wr(RX_CTRL, 32'h5);
      wr(TX_PTR, 32'h0000_0300);
      wr(TX_CNT, 1);
      @(negedge clk);
      rx_req = 1'b1; tx_req = 1'b1; rx_data = 32'h1111_2222;
      #1;
      chk("R9", "rx_ack on tie", rx_ack, 1);
      chk("R9", "tx held on tie", tx_load, 0);
      @(negedge clk);
      rx_req = 1'b0;
      #1;
      chk("R9", "rx write first", {mem_we, tx_load}, 2'b10);
      chk("R9", "rx write addr", mem_addr, 32'h0000_8100);
      @(negedge clk);
      #1;
      chk("R9", "tx after rx", tx_load, 1);
      chk("R9", "tx addr", mem_addr, 32'h0000_0300);
      @(negedge clk);
      tx_req = 1'b0;

      // R10: waiting read is held and not pre-empted
      wr(RX_PTR, 32'h0000_8200);
      wr(RX_CNT, 1);
      wr(TX_PTR, 32'h0000_0400);
      wr(TX_CNT, 1);
      @(negedge clk);
      mem_gnt = 1'b0; tx_req = 1'b1;
      #1;
      chk("R10", "read pending", {mem_req, mem_we, tx_load}, 3'b100);
      @(negedge clk);
      rx_req = 1'b1; rx_data = 32'h3333_4444;
      #1;
      chk("R10", "no pre-empt", rx_ack, 0);
      chk("R10", "addr held", mem_addr, 32'h0000_0400);
      @(negedge clk);
      mem_gnt = 1'b1;
      #1 chk("R10", "granted load", tx_load, 1);
      @(negedge clk);
      tx_req = 1'b0;
      #1 chk("R10", "rx served next", rx_ack, 1);
      @(negedge clk);
      rx_req = 1'b0;
      #1;
      chk("R10", "rx write addr", mem_addr, 32'h0000_8200);
      chk("R10", "rx write data", mem_wdata, 32'h3333_4444);
      @(negedge clk);
      #1 chk("R7", "all_done final", all_done, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule